// File: doc/BRIEF.md
# Set/Clear Register Interrupt Controller

This block collects 32 interrupt sources and turns them into two request lines and one wakeup line. Software changes each configuration word only by writing ones to a "set" address or a "clear" address. A zero bit in such a write leaves that bit alone, so two agents can change different sources without a read-modify-write.

For each source the controller holds a three-bit trigger code, a routing bit, a mask enable and a wakeup enable. Inputs pass through a two-flop synchronizer. The synchronized level is then either used directly (level modes) or turned into latched rising and falling edges (edge modes). Each source becomes pending according to its code.

A pending, unmasked source shows up in the status word of the request line it is routed to, and each request output is the OR of its status word. The wakeup output is the OR of the pending sources whose wakeup bit is set. All three outputs are registered.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration word (codes, routing, mask, wakeup) and both edge latch words read 0, and req0_o, req1_o and wake_o are 0.
- R2: Each configuration word has three word addresses: read at 3k, set at 3k+1 and clear at 3k+2. The words are k=0 code bit 0, k=1 code bit 1, k=2 code bit 2, k=3 routing, k=4 mask and k=5 wakeup enable. A write of 1 to a bit at the set address makes it 1 and at the clear address makes it 0. Bits written as 0 keep their value.
- R3: Trigger code {bit2,bit1,bit0} = 101 makes a source pending while its synchronized input is high, and 110 makes it pending while the input is low.
- R4: Codes 000, 100 and 111 never make a source pending, whatever its input does.
- R5: A rising edge of a synchronized input sets that source's bit in the rise latch (address 18), and a falling edge sets it in the fall latch (address 19), whatever the code. Code 001 makes the source pending on its rise latch, 010 on its fall latch, and 011 on either.
- R6: A source with routing bit 1 is reported on request 0. A source with routing bit 0 is reported on request 1.
- R7: The request-0 status word (address 20) and request-1 status word (address 21) hold exactly the pending, unmasked sources routed to that request. A masked source appears in neither word.
- R8: Writing to address 18 or 19 clears the latch bits written as 1 and keeps those written as 0. An all-ones write clears every latched edge.
- R9: req0_o and req1_o are the registered OR of their status words. wake_o is the registered OR of pending sources with wakeup enabled, whatever their mask. A level change on src_i reaches the outputs at the third rising clock edge.
- R10: Clearing and then setting the mask bit of a source whose level stays active drops its request and then raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt source levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data, one bit per source |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wakeup line |

## Verification
The assertions check on every cycle:
- the set and clear semantics of the mask word;
- that disabled codes never produce a pending bit;
- that the two status words never share a source and hold no masked source;
- that each output follows the OR of its vector one cycle later.

Only the bench's scenarios can show:
- the meaning of each trigger code against real input waveforms;
- edge latching and its write-one-to-clear behaviour;
- the exact three-edge latency;
- that a mask toggle on a held level re-raises its request.

// File: rtl/irq_setclr_pkg.sv
// Package: shared constants for the set/clear interrupt controller.
// Assumes word addresses of 5 bits and six set/clear configuration words.
package irq_setclr_pkg;
    localparam int NUM_CFG  = 6;   // configuration words with set/clear access
    localparam int K_CODE0  = 0;
    localparam int K_CODE1  = 1;
    localparam int K_CODE2  = 2;
    localparam int K_ROUTE  = 3;
    localparam int K_MASK   = 4;
    localparam int K_WAKE   = 5;
    localparam int ADR_RISE = 18;  // rise latch, read / write-one-to-clear
    localparam int ADR_FALL = 19;  // fall latch, read / write-one-to-clear
    localparam int ADR_ST0  = 20;  // request-0 status
    localparam int ADR_ST1  = 21;  // request-1 status
    localparam int ADR_RAW  = 22;  // synchronized inputs

    // trigger codes {bit2,bit1,bit0}
    localparam logic [2:0] TRG_RISE = 3'b001;
    localparam logic [2:0] TRG_FALL = 3'b010;
    localparam logic [2:0] TRG_BOTH = 3'b011;
    localparam logic [2:0] TRG_HIGH = 3'b101;
    localparam logic [2:0] TRG_LOW  = 3'b110;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes every bit is an independent level; no bus coherence is implied.
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the inputs through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irq_setclr_reg.sv
// Module: irq_setclr_reg
// One configuration word changed only by write-one-to-set and
// write-one-to-clear strobes. Assumes both strobes never fire together
// (they come from distinct addresses).
module irq_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    // Apply the set or clear pattern; zero bits are left untouched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (set_we)
            q <= q | bits;
        else if (clr_we)
            q <= q & ~bits;
    end
endmodule

// File: rtl/irq_trigger.sv
// Module: irq_trigger
// Per-source edge detection, edge latches and trigger-code decode into a
// pending vector. Assumes lvl is already synchronized to clk. A new edge
// wins over a clear arriving in the same cycle.
module irq_trigger
    import irq_setclr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] code0,
    input  logic [W-1:0] code1,
    input  logic [W-1:0] code2,
    input  logic [W-1:0] rise_clr,
    input  logic [W-1:0] fall_clr,
    output logic [W-1:0] rise_lat,
    output logic [W-1:0] fall_lat,
    output logic [W-1:0] pend
);
    logic [W-1:0] lvl_d;
    logic [W-1:0] rise_ev;
    logic [W-1:0] fall_ev;

    assign rise_ev = lvl & ~lvl_d;
    assign fall_ev = ~lvl & lvl_d;

    // Remember last level and accumulate edges until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d    <= '0;
            rise_lat <= '0;
            fall_lat <= '0;
        end else begin
            lvl_d    <= lvl;
            rise_lat <= (rise_lat & ~rise_clr) | rise_ev;
            fall_lat <= (fall_lat & ~fall_clr) | fall_ev;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_src
        // Select the pending condition named by this source's code.
        always_comb begin
            case ({code2[i], code1[i], code0[i]})
                TRG_HIGH: pend[i] = lvl[i];
                TRG_LOW:  pend[i] = ~lvl[i];
                TRG_RISE: pend[i] = rise_lat[i];
                TRG_FALL: pend[i] = fall_lat[i];
                TRG_BOTH: pend[i] = rise_lat[i] | fall_lat[i];
                default:  pend[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irq_setclr_ctrl.sv
// Module: irq_setclr_ctrl (top)
// Interrupt controller with set/clear configuration words, trigger decode,
// two routed request lines and a wakeup line. Assumes a single-cycle
// register bus: writes take effect at the clock edge, reads are
// combinational.
module irq_setclr_ctrl
    import irq_setclr_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [N_SRC-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [N_SRC-1:0] rd_data,
    output logic             req0_o,
    output logic             req1_o,
    output logic             wake_o
);
    logic [N_SRC-1:0] cfg_q [NUM_CFG];
    logic [N_SRC-1:0] lvl_s;
    logic [N_SRC-1:0] code0_q, code1_q, code2_q, route_q, mask_q, wake_q;
    logic [N_SRC-1:0] rise_lat, fall_lat, pend;
    logic [N_SRC-1:0] rise_clr, fall_clr;
    logic [N_SRC-1:0] stat0, stat1, wake_vec;

    irq_sync #(.W(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_i),
        .q     (lvl_s)
    );

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        logic set_hit;
        logic clr_hit;
        assign set_hit = wr_en && (wr_addr == AW'(3 * k + 1));
        assign clr_hit = wr_en && (wr_addr == AW'(3 * k + 2));
        irq_setclr_reg #(.W(N_SRC)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_hit),
            .clr_we (clr_hit),
            .bits   (wr_data),
            .q      (cfg_q[k])
        );
    end

    assign code0_q = cfg_q[K_CODE0];
    assign code1_q = cfg_q[K_CODE1];
    assign code2_q = cfg_q[K_CODE2];
    assign route_q = cfg_q[K_ROUTE];
    assign mask_q  = cfg_q[K_MASK];
    assign wake_q  = cfg_q[K_WAKE];

    assign rise_clr = (wr_en && wr_addr == AW'(ADR_RISE)) ? wr_data : '0;
    assign fall_clr = (wr_en && wr_addr == AW'(ADR_FALL)) ? wr_data : '0;

    irq_trigger #(.W(N_SRC)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_s),
        .code0    (code0_q),
        .code1    (code1_q),
        .code2    (code2_q),
        .rise_clr (rise_clr),
        .fall_clr (fall_clr),
        .rise_lat (rise_lat),
        .fall_lat (fall_lat),
        .pend     (pend)
    );

    assign stat0    = pend & mask_q & route_q;
    assign stat1    = pend & mask_q & ~route_q;
    assign wake_vec = pend & wake_q;

    // Register the three reduced outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req0_o <= 1'b0;
            req1_o <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            req0_o <= |stat0;
            req1_o <= |stat1;
            wake_o <= |wake_vec;
        end
    end

    // Return the word selected by the read address.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CFG; k++)
            if (rd_addr == AW'(3 * k))
                rd_data = cfg_q[k];
        if (rd_addr == AW'(ADR_RISE)) rd_data = rise_lat;
        if (rd_addr == AW'(ADR_FALL)) rd_data = fall_lat;
        if (rd_addr == AW'(ADR_ST0))  rd_data = stat0;
        if (rd_addr == AW'(ADR_ST1))  rd_data = stat1;
        if (rd_addr == AW'(ADR_RAW))  rd_data = lvl_s;
    end
endmodule

// File: rtl/irq_setclr_chk.sv
// Module: irq_setclr_chk
// Property checker bound to irq_setclr_ctrl. Observes only; drives nothing.
module irq_setclr_chk #(
    parameter int N_SRC = 32,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [N_SRC-1:0] wr_data,
    input logic [N_SRC-1:0] code0_q,
    input logic [N_SRC-1:0] code1_q,
    input logic [N_SRC-1:0] code2_q,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] pend,
    input logic [N_SRC-1:0] stat0,
    input logic [N_SRC-1:0] stat1,
    input logic [N_SRC-1:0] wake_vec,
    input logic             req0_o,
    input logic             req1_o,
    input logic             wake_o
);
    localparam logic [AW-1:0] A_MSET = AW'(13);
    localparam logic [AW-1:0] A_MCLR = AW'(14);

    p_rst_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!req0_o && !req1_o && !wake_o));

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MSET) |=> mask_q == ($past(mask_q) | $past(wr_data)));

    p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MCLR) |=> mask_q == ($past(mask_q) & ~$past(wr_data)));

    p_code_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~code1_q & ~code0_q) == '0));

    p_route_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 & stat1) == '0));

    p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((stat0 | stat1) & ~mask_q) == '0));

    p_req_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req0_o == $past(|stat0)) && (req1_o == $past(|stat1)));

    p_wake_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wake_o == $past(|wake_vec));

    // code2 is only ever checked through the codes above; keep it observed
    p_code_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & code2_q & code1_q & code0_q) == '0));
endmodule

bind irq_setclr_ctrl irq_setclr_chk #(.N_SRC(N_SRC), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .code0_q  (code0_q),
    .code1_q  (code1_q),
    .code2_q  (code2_q),
    .mask_q   (mask_q),
    .pend     (pend),
    .stat0    (stat0),
    .stat1    (stat1),
    .wake_vec (wake_vec),
    .req0_o   (req0_o),
    .req1_o   (req1_o),
    .wake_o   (wake_o)
);

// File: tb/tb_irq_setclr_ctrl.sv
module tb_irq_setclr_ctrl;
    localparam int N  = 32;
    localparam int AW = 5;
    localparam int NV = 14;

    // entry: {wr addr(31 = no write), wr data, src, exp {req0,req1,wake}}
    localparam logic [71:0] VEC [NV] = '{
        {5'd1,  32'h1, 32'h0, 3'b000},
        {5'd7,  32'h1, 32'h0, 3'b000},
        {5'd10, 32'h1, 32'h0, 3'b000},
        {5'd13, 32'h1, 32'h0, 3'b000},
        {5'd31, 32'h0, 32'h1, 3'b100},
        {5'd16, 32'h1, 32'h1, 3'b101},
        {5'd11, 32'h1, 32'h1, 3'b011},
        {5'd14, 32'h1, 32'h1, 3'b001},
        {5'd13, 32'h1, 32'h1, 3'b011},
        {5'd31, 32'h0, 32'h0, 3'b000},
        {5'd4,  32'h2, 32'h0, 3'b000},
        {5'd7,  32'h2, 32'h0, 3'b000},
        {5'd13, 32'h2, 32'h0, 3'b010},
        {5'd31, 32'h0, 32'h2, 3'b000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_i = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [N-1:0]  rd_data;
    logic          req0_o, req1_o, wake_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_setclr_ctrl #(.N_SRC(N), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        #1 v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] outs();
        return {29'd0, req0_o, req1_o, wake_o};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [71:0] e;
        // R1: reset state
        wait_cyc(3);
        check("R1 outputs", outs(), 32'h0);
        for (int a = 0; a < 20; a += 3) begin
            rd(a, v);
            check("R1 cfg word", v, 32'h0);
        end
        rd(19, v);
        check("R1 fall latch", v, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // R3 R6 R7 R9: vector walk
        for (int i = 0; i < NV; i++) begin
            e = VEC[i];
            @(negedge clk) src_i = e[34:3];
            if (e[71:67] != 5'd31) wr(int'(e[71:67]), e[66:35]);
            wait_cyc(5);
            check("R3/R6/R9 vector", outs(), {29'd0, e[2:0]});
        end

        // R2: readback and zero bits unchanged
        rd(0, v);  check("R2 code0", v, 32'h1);
        rd(3, v);  check("R2 code1", v, 32'h2);
        rd(6, v);  check("R2 code2", v, 32'h3);
        rd(9, v);  check("R2 route", v, 32'h0);
        rd(15, v); check("R2 wake", v, 32'h1);
        wr(13, 32'h0);
        rd(12, v); check("R2 mask zero write", v, 32'h3);

        // R9: three-edge latency of a level change
        @(negedge clk) src_i = 32'h3;
        @(posedge clk); @(posedge clk);
        @(negedge clk) check("R9 latency early", {31'd0, req1_o}, 32'h0);
        @(posedge clk);
        @(negedge clk) check("R9 latency on", {31'd0, req1_o}, 32'h1);

        // R7: status words
        rd(21, v); check("R7 status1", v, 32'h1);
        rd(20, v); check("R7 status0", v, 32'h0);

        // R10: mask toggle on held level
        wr(14, 32'h1); wait_cyc(4);
        check("R10 masked", {31'd0, req1_o}, 32'h0);
        rd(21, v); check("R7 masked absent", v, 32'h0);
        wr(13, 32'h1); wait_cyc(4);
        check("R10 re-raised", {31'd0, req1_o}, 32'h1);
        @(negedge clk) src_i = 32'h2;
        wait_cyc(5);

        // R4: code 100 on source 3, code 000 on source 4
        wr(7, 32'h8); wr(13, 32'h18); wr(10, 32'h18);
        @(negedge clk) src_i = 32'h1A;
        wait_cyc(6);
        check("R4 disabled codes", {31'd0, req0_o}, 32'h0);
        rd(20, v); check("R4 status0", v, 32'h0);

        // R5 R8: rising-edge mode on source 2
        wr(18, 32'hFFFF_FFFF); wr(19, 32'hFFFF_FFFF);
        wr(1, 32'h4); wr(13, 32'h4); wr(10, 32'h4);
        wait_cyc(3);
        check("R5 idle edge mode", {31'd0, req0_o}, 32'h0);
        @(negedge clk) src_i = 32'h1E;
        wait_cyc(3);
        @(negedge clk) src_i = 32'h1A;
        wait_cyc(6);
        check("R5 rise latched", {31'd0, req0_o}, 32'h1);
        rd(18, v); check("R5 rise latch", v & 32'h4, 32'h4);
        rd(19, v); check("R5 fall latch", v & 32'h4, 32'h4);
        wr(18, 32'h0);
        rd(18, v); check("R8 zero write keeps", v & 32'h4, 32'h4);
        wr(18, 32'h4); wait_cyc(3);
        check("R8 cleared req", {31'd0, req0_o}, 32'h0);
        rd(18, v); check("R8 rise cleared", v & 32'h4, 32'h0);
        wr(19, 32'hFFFF_FFFF);
        rd(19, v); check("R8 all ones", v, 32'h0);

        // R5: code 011 reacts to a falling edge
        wr(4, 32'h4);
        @(negedge clk) src_i = 32'h1E;
        wait_cyc(5);
        wr(18, 32'h4); wait_cyc(3);
        check("R5 either idle", {31'd0, req0_o}, 32'h0);
        @(negedge clk) src_i = 32'h1A;
        wait_cyc(6);
        check("R5 either fall", {31'd0, req0_o}, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule